// File: doc/BRIEF.md
# Accumulator Round-and-Clamp Readout

This block turns a set of wide signed accumulators into one 64-bit packed vector of narrow lanes. Two lane layouts share the same 192-bit accumulator bus: four halfword lanes, each fed by a 48-bit accumulator and giving a 16-bit result, or eight byte lanes, each fed by a 24-bit accumulator and giving an 8-bit result. Every lane is shifted right by its own amount, rounded in one of six modes and saturated to the output width.

The rounding modes come in signed and unsigned pairs: round to nearest with ties away from zero, round to nearest with ties to even, and truncate. Lane results whose value cannot be defined (a negative shift, or a mode that the format does not support) come out as zero, and a per-lane flag is raised. The result is registered, so it appears one clock after the request strobe and holds until the next strobe.

Top module: `acc_round_clamp`

## Requirements
- R1: fmt_i=1 selects halfword lanes: lane g uses acc_i[48g+47:48g], the signed two's-complement amount shift_i[16g+15:16g] and result_o[16g+15:16g], and unpred_o[7:4] stay 0. fmt_i=0 selects byte lanes: lane g uses acc_i[24g+23:24g], the unsigned amount shift_i[8g+7:8g] and result_o[8g+7:8g]. Mode 5 (unsigned truncate) gives floor(u / 2^s) saturated, where u is the accumulator read as an unsigned value.
- R2: Mode 0 (nearest, ties away, signed, halfword only): let q = floor(a / 2^s) and r = a − q·2^s. When bit 47 is 0, add 1 if s>0 and r ≥ 2^(s−1), then saturate at 32767. When bit 47 is 1, add 1 only if s>0 and r > 2^(s−1), then saturate at −32768.
- R3: Modes 2 (signed) and 3 (unsigned), nearest with ties to even: add 1 when r > 2^(s−1), and add the low bit of q when r = 2^(s−1) exactly. Mode 2 saturates toward the side given by bit 47.
- R4: Mode 1 (nearest, ties away, unsigned) reads u, adds 1 when s>0 and r ≥ 2^(s−1), and saturates at 0xFFFF for halfwords or 0xFF for bytes.
- R5: A lane result is 0 without a flag when the shift exceeds the accumulator width W (48 or 24); modes 2 and 4 already give 0 above 47; byte mode 5 gives 0 at 24 and above.
- R6: At a shift of exactly W, mode 1 returns the top accumulator bit, mode 3 returns 1 only when u > 2^(W−1), and halfword mode 5 also returns 1 only when u > 2^(W−1).
- R7: A negative halfword shift amount gives a 0 lane result and sets that lane's unpred_o bit.
- R8: Modes 6 and 7 in either format, and the signed modes 0, 2 and 4 in byte format, give 0 on every active lane and set every active lane's unpred_o bit.
- R9: After reset, valid_o, result_o and unpred_o are 0. A result appears on the clock edge after valid_i is sampled high, valid_o is valid_i delayed by one cycle, and outputs hold while valid_i is low.
- R10: Mode 4 (signed truncate) gives floor(a / 2^s) and saturates at 32767 when bit 47 is 0 or at −32768 when bit 47 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| fmt_i | input | 1 | 1 = four halfword lanes, 0 = eight byte lanes |
| mode_i | input | 3 | Rounding mode, 0 to 5 |
| acc_i | input | 192 | Packed accumulators |
| shift_i | input | 64 | Packed per-lane shift amounts |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Packed rounded and saturated lanes |
| unpred_o | output | 8 | Per-lane unpredictable-result flag |

## Verification
A wrong round bit, sticky bit or saturation choice shows up only in the lane and mode that reach it. It appears in result_o on the cycle after that request and nowhere else, because the block keeps no state from one request to the next. The sweep therefore crosses every mode with every shift from below zero to past the accumulator width. It uses accumulator values built to land exactly on ties, just above ties and on the sign and saturation boundaries, so that a defect is seen on the first request that hits it.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;
  localparam int ACC_BUS_W = 192;
  localparam int RES_W     = 64;
  localparam int H_LANES   = 4;
  localparam int B_LANES   = 8;
  localparam int H_ACC_W   = ACC_BUS_W / H_LANES;
  localparam int B_ACC_W   = ACC_BUS_W / B_LANES;
  localparam int H_OUT_W   = RES_W / H_LANES;
  localparam int B_OUT_W   = RES_W / B_LANES;
  localparam int H_SH_W    = RES_W / H_LANES;
  localparam int B_SH_W    = RES_W / B_LANES;

  typedef enum logic [2:0] {
    RND_AWAY_S  = 3'd0,
    RND_AWAY_U  = 3'd1,
    RND_EVEN_S  = 3'd2,
    RND_EVEN_U  = 3'd3,
    RND_TRUNC_S = 3'd4,
    RND_TRUNC_U = 3'd5
  } rnd_mode_e;
endpackage

// File: rtl/rc_lane.sv
module rc_lane
  import acc_round_pkg::*;
#(
  parameter int ACC_W     = 48,
  parameter int OUT_W     = 16,
  parameter int SH_W      = 16,
  parameter int SIGNED_OK = 1
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [2:0]       mode_i,
  output logic [OUT_W-1:0] res_o,
  output logic             unpred_o
);
  localparam int TW = ACC_W + 2;
  localparam logic [TW-1:0]        UMAX = {{(TW-OUT_W){1'b0}}, {OUT_W{1'b1}}};
  localparam logic signed [TW-1:0] SMAX = {{(TW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [TW-1:0] SMIN = {{(TW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]     MID  = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic [OUT_W-1:0] sat_u(input logic [TW-1:0] v);
    return (v > UMAX) ? {OUT_W{1'b1}} : v[OUT_W-1:0];
  endfunction

  function automatic logic [OUT_W-1:0] sat_s(input logic signed [TW-1:0] v, input logic neg);
    if (!neg) return (v > SMAX) ? SMAX[OUT_W-1:0] : v[OUT_W-1:0];
    return (v < SMIN) ? SMIN[OUT_W-1:0] : v[OUT_W-1:0];
  endfunction

  logic signed [SH_W:0]    sh_ext;
  int                      s;
  logic                    rbit, lnz, neg, above_mid;
  logic [ACC_W-1:0]        lowmask;
  logic [TW-1:0]           tu;
  logic signed [TW-1:0]    as_v, ts;

  assign sh_ext = (SIGNED_OK != 0) ? {shamt_i[SH_W-1], shamt_i} : {1'b0, shamt_i};
  assign neg       = acc_i[ACC_W-1];
  assign above_mid = acc_i > MID;
  assign as_v      = {{2{acc_i[ACC_W-1]}}, acc_i};

  always_comb begin
    s       = int'(sh_ext);
    rbit    = 1'b0;
    lnz     = 1'b0;
    lowmask = '0;
    if (s >= 1 && s <= ACC_W) begin
      rbit    = |(acc_i & (ACC_W'(1) << (s - 1)));
      lowmask = (ACC_W'(1) << (s - 1)) - ACC_W'(1);
      lnz     = |(acc_i & lowmask);
    end
    tu = {2'b00, acc_i} >> s;
    ts = as_v >>> s;
    res_o    = '0;
    unpred_o = 1'b0;
    if (mode_i > 3'(RND_TRUNC_U) || ((SIGNED_OK == 0) && !mode_i[0]) || s < 0) begin
      unpred_o = 1'b1;
    end else begin
      case (mode_i)
        3'(RND_AWAY_U): begin
          if (s == ACC_W) res_o = OUT_W'(neg);
          else if (s < ACC_W) res_o = sat_u(tu + TW'(rbit));
        end
        3'(RND_EVEN_U): begin
          if (s == ACC_W) res_o = OUT_W'(above_mid);
          else if (s < ACC_W) res_o = sat_u(tu + TW'(rbit & (lnz | tu[0])));
        end
        3'(RND_TRUNC_U): begin
          if (s == ACC_W) res_o = (SIGNED_OK != 0) ? OUT_W'(above_mid) : '0;
          else if (s < ACC_W) res_o = sat_u(tu);
        end
        3'(RND_AWAY_S): begin
          // negative ties truncate toward minus infinity
          if (s <= ACC_W) res_o = sat_s(ts + TW'(neg ? (rbit & lnz) : rbit), neg);
        end
        3'(RND_EVEN_S): begin
          if (s < ACC_W) res_o = sat_s(ts + TW'(rbit & (lnz | ts[0])), neg);
        end
        default: begin
          if (s < ACC_W) res_o = sat_s(ts, neg);
        end
      endcase
    end
  end
endmodule

// File: rtl/acc_round_clamp.sv
module acc_round_clamp
  import acc_round_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 fmt_i,
  input  logic [2:0]           mode_i,
  input  logic [ACC_BUS_W-1:0] acc_i,
  input  logic [RES_W-1:0]     shift_i,
  output logic                 valid_o,
  output logic [RES_W-1:0]     result_o,
  output logic [B_LANES-1:0]   unpred_o
);
  logic [RES_W-1:0]   h_res, b_res, nxt_res;
  logic [H_LANES-1:0] h_fl;
  logic [B_LANES-1:0] b_fl, nxt_fl;

  for (genvar g = 0; g < H_LANES; g++) begin : g_half
    rc_lane #(.ACC_W(H_ACC_W), .OUT_W(H_OUT_W), .SH_W(H_SH_W), .SIGNED_OK(1)) u_lane (
      .acc_i   (acc_i[H_ACC_W*g +: H_ACC_W]),
      .shamt_i (shift_i[H_SH_W*g +: H_SH_W]),
      .mode_i  (mode_i),
      .res_o   (h_res[H_OUT_W*g +: H_OUT_W]),
      .unpred_o(h_fl[g])
    );
  end

  for (genvar g = 0; g < B_LANES; g++) begin : g_byte
    rc_lane #(.ACC_W(B_ACC_W), .OUT_W(B_OUT_W), .SH_W(B_SH_W), .SIGNED_OK(0)) u_lane (
      .acc_i   (acc_i[B_ACC_W*g +: B_ACC_W]),
      .shamt_i (shift_i[B_SH_W*g +: B_SH_W]),
      .mode_i  (mode_i),
      .res_o   (b_res[B_OUT_W*g +: B_OUT_W]),
      .unpred_o(b_fl[g])
    );
  end

  assign nxt_res = fmt_i ? h_res : b_res;
  assign nxt_fl  = fmt_i ? {{(B_LANES-H_LANES){1'b0}}, h_fl} : b_fl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      unpred_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= nxt_res;
        unpred_o <= nxt_fl;
      end
    end
  end

  p_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(unpred_o)));
  p_byte_signed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_i && !mode_i[0]) |=> (unpred_o == '1 && result_o == '0));
  p_neg_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i && shift_i[H_SH_W-1]) |=> (unpred_o[0] && result_o[H_OUT_W-1:0] == '0));
  p_half_flags_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i) |=> (unpred_o[B_LANES-1:H_LANES] == '0));
  p_big_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_i && mode_i[0] && mode_i <= 3'd5 && shift_i[B_SH_W-1:0] > 8'(B_ACC_W))
    |=> (result_o[B_OUT_W-1:0] == '0 && !unpred_o[0]));
endmodule

// File: tb/tb_acc_round_clamp.sv
module tb_acc_round_clamp;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         fmt_i = 1'b0;
  logic [2:0]   mode_i = '0;
  logic [191:0] acc_i = '0;
  logic [63:0]  shift_i = '0;
  logic         valid_o;
  logic [63:0]  result_o;
  logic [7:0]   unpred_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #2 clk_i = ~clk_i;

  acc_round_clamp dut (.*);

  // reference lane value: {flag, result}; W = accumulator width, O = output width
  function automatic longint ref_lane(bit half, int mode, longint u, int s);
    int W = half ? 48 : 24;
    int O = half ? 16 : 8;
    longint top = longint'(1) << (W - 1);
    longint umax = (longint'(1) << O) - 1;
    longint smax = (longint'(1) << (O - 1)) - 1;
    longint smin = -(longint'(1) << (O - 1));
    longint a, q, r, h, p;
    if (mode > 5 || (!half && mode % 2 == 0) || s < 0) return longint'(1) << 32;
    a = (u >= top) ? u - (longint'(1) << W) : u;
    if (mode % 2 == 1) begin
      if (s > W) return 0;
      if (s == W) begin
        if (mode == 1) return (u >= top) ? 1 : 0;
        if (mode == 3) return (u > top) ? 1 : 0;
        return (half && u > top) ? 1 : 0;
      end
      p = longint'(1) << s; q = u / p; r = u % p; h = p / 2;
      if (s > 0 && mode == 1 && r >= h) q++;
      if (s > 0 && mode == 3 && (r > h || (r == h && q % 2 == 1))) q++;
      return (q > umax) ? umax : q;
    end
    if (s > W || (mode != 0 && s > W - 1)) return 0;
    p = longint'(1) << s; q = a >>> s; r = a - q * p; h = p / 2;
    if (s > 0 && mode == 0 && ((a >= 0 && r >= h) || (a < 0 && r > h))) q++;
    if (s > 0 && mode == 2 && (r > h || (r == h && (q & 1) == 1))) q++;
    if (a >= 0) q = (q > smax) ? smax : q;
    else        q = (q < smin) ? smin : q;
    return q & umax;
  endfunction

  function automatic string tag_of(bit half, int mode, int s, longint e);
    int W = half ? 48 : 24;
    if (e[32]) return (s < 0) ? "R7" : "R8";
    if (s > W || (mode % 2 == 0 && s > W - 1 && mode != 0) || (!half && mode == 5 && s >= W)) return "R5";
    if (s == W) return "R6";
    case (mode)
      0: return "R2";
      1: return "R4";
      2, 3: return "R3";
      4: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic longint lane_val(int set, int lane, int s, int W);
    longint m = (longint'(1) << W) - 1;
    longint mid = longint'(1) << (W - 1);
    longint unsigned x = longint'(set * 131 + lane * 17 + s * 7 + 1) * 64'h9E3779B97F4A7C15;
    longint v;
    x = x ^ (x >> 29);
    v = longint'(x) & m;
    if (set % 4 == 1 && s >= 1 && s <= W) v = ((v << s) | (longint'(1) << (s - 1))) & m;
    if (set % 4 == 2 && s >= 2 && s <= W) v = ((v << s) | (longint'(1) << (s - 1)) | 1) & m;
    if (set % 4 == 3) begin
      case (lane)
        0: v = 0;
        1: v = m;
        2: v = mid;
        3: v = mid - 1;
        4: v = mid + 1;
        5: v = 1;
        6: v = m - 1;
        default: ;
      endcase
    end
    return v;
  endfunction

  task automatic run_txn(bit half, int mode, int s, int set);
    int lanes = half ? 4 : 8;
    int W = half ? 48 : 24;
    int O = half ? 16 : 8;
    longint vals[8];
    @(negedge clk_i);
    fmt_i = half; mode_i = 3'(mode); valid_i = 1'b1;
    for (int g = 0; g < lanes; g++) begin
      vals[g] = lane_val(set, g, s, W);
      if (half) begin
        acc_i[48*g +: 48] = vals[g][47:0];
        shift_i[16*g +: 16] = 16'(s);
      end else begin
        acc_i[24*g +: 24] = vals[g][23:0];
        shift_i[8*g +: 8] = 8'(s);
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1) begin
      failures++; $display("FAIL R9 valid_o actual=%0b expected=1", valid_o);
    end
    if (half) begin
      checks++;
      if (unpred_o[7:4] !== 4'b0) begin
        failures++; $display("FAIL R1 upper flags actual=%h expected=0", unpred_o[7:4]);
      end
    end
    for (int g = 0; g < lanes; g++) begin
      longint e = ref_lane(half, mode, vals[g], half ? s : (s & 255));
      longint got = half ? longint'(result_o[16*g +: 16]) : longint'(result_o[8*g +: 8]);
      checks++;
      if (got != (e & ((longint'(1) << O) - 1)) || unpred_o[g] !== e[32]) begin
        failures++;
        $display("FAIL %s fmt=%0d mode=%0d s=%0d lane=%0d acc=%h actual=%h/%0b expected=%h/%0b",
                 tag_of(half, mode, s, e), half, mode, s, g, vals[g], got, unpred_o[g],
                 e & ((longint'(1) << O) - 1), e[32]);
      end
    end
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || unpred_o !== '0) begin
      failures++; $display("FAIL R9 reset actual=%0b/%h/%h expected=0/0/0", valid_o, result_o, unpred_o);
    end
    rst_ni = 1'b1;
    // byte lanes: shifts 0..27 and 255
    for (int si = 0; si <= 28; si++)
      for (int mode = 0; mode < 8; mode++)
        for (int set = 0; set < 12; set++)
          run_txn(1'b0, mode, (si == 28) ? 255 : si, set);
    // halfword lanes: shifts -3..50
    for (int si = 0; si <= 53; si++)
      for (int mode = 0; mode < 8; mode++)
        for (int set = 0; set < 12; set++)
          run_txn(1'b1, mode, si - 3, set);
    // R9: idle cycles leave outputs untouched
    held = result_o;
    @(negedge clk_i);
    acc_i = ~acc_i; shift_i = 64'h0101010101010101; mode_i = 3'd1;
    @(negedge clk_i);
    checks++;
    if (result_o !== held || valid_o !== 1'b0) begin
      failures++; $display("FAIL R9 hold actual=%h/%0b expected=%h/0", result_o, valid_o, held);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule